// File: doc/BRIEF.md
# DRAM Rank Boundary Decoder

This block turns a physical address into a DRAM rank index and a channel number for a memory controller with two channels of four ranks each. Configuration arrives as eight 8-bit cumulative rank limits, four per channel, in 32 MiB units. It also takes four attribute bytes, each holding the page-size codes of two ranks. A request is a 33-bit address with a valid strobe. One cycle later the block returns the rank, the channel, the page-size code of that rank, a flag for interleaved mode, an out-of-range flag and a configuration-error flag.

The block compares the two channels' configuration by itself. When both channels are populated identically it decodes in interleaved mode. In that mode the channel 0 limits are doubled and address bit 7 picks the channel. Otherwise the channels are stacked: channel 1's ranks start where channel 0's top limit ends. Ranks whose limit equals the previous limit hold no memory and are never selected.

Top module: `rbd_decoder`

## Requirements
- R1: The response fields are registered. `rsp_valid` is high exactly one cycle after `req_valid` was high. When `req_valid` is low, the response fields keep their previous values.
- R2: The address unit is `req_addr[32:25]`. Boundary byte for channel c, rank r sits at `cfg_bound[8*(4*c+r) +: 8]`. Within a sequence of limits L, entry k covers units from L[k-1] (0 for the first) up to but not including L[k].
- R3: A rank whose limit equals the preceding limit is empty and is never reported.
- R4: Interleaved mode is chosen exactly when every 3-bit attribute field and every boundary byte of channel 0 equals its channel 1 counterpart. Attribute bits 3 and 7 take no part in the comparison.
- R5: In interleaved mode the limits are twice the channel 0 boundaries, and `rsp_chan` equals address bit 7.
- R6: In non-interleaved mode the limit sequence is the four channel 0 boundaries, followed by the four channel 1 boundaries each increased by the channel 0 rank 3 boundary. Hits in the first four report channel 0; hits in the last four report channel 1.
- R7: A unit at or above the top limit sets `rsp_out_of_range`. Rank, channel, page code and configuration error are then all zero.
- R8: `rsp_page` is the 3-bit attribute code of the selected rank. It is taken from attribute byte `cfg_attr[8*(2*c+r/2) +: 8]`, bits 2:0 for even r and bits 6:4 for odd r.
- R9: A selected rank whose code is 001, 101, 110 or 111 sets `rsp_cfg_err` and still decodes. Codes 000, 010, 011 and 100 never set it.
- R10: `rsp_interleaved` reports the mode that was used for the decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_bound | input | 64 | Cumulative rank boundaries, 32 MiB units |
| cfg_attr | input | 32 | Rank page-size attribute bytes |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 33 | Physical address |
| rsp_valid | output | 1 | Response valid |
| rsp_rank | output | 2 | Selected rank within its channel |
| rsp_chan | output | 1 | Selected channel |
| rsp_page | output | 3 | Attribute code of the selected rank |
| rsp_interleaved | output | 1 | Interleaved decode in use |
| rsp_out_of_range | output | 1 | Address beyond the top limit |
| rsp_cfg_err | output | 1 | Selected rank has a reserved code |

## Verification
The bound checker watches several properties on every cycle:
- the valid flag's one-cycle delay and the holding of fields when no request arrives;
- all-zero fields on an out-of-range response;
- channel equal to address bit 7 in interleaved responses;
- agreement between the error flag and the reported code.

Which rank an address falls in, how empty ranks are skipped, and how the mode follows from the configuration can only be shown by the bench. It sweeps every address unit with both values of bit 7 across several configurations: stacked with empty ranks, identical, identical except for reserved bits, one limit apart, and with reserved codes.

// File: rtl/rbd_pkg.sv
package rbd_pkg;
    localparam int CH_N    = 2;
    localparam int RK_N    = 4;
    localparam int BND_W   = 8;
    localparam int CODE_W  = 3;
    localparam int RK_W    = $clog2(RK_N);
    localparam int IDX_W   = $clog2(CH_N * RK_N);
    localparam int LIM_W   = BND_W + 1;
    localparam int PAIR_N  = RK_N / 2;

    typedef logic [CH_N-1:0][RK_N-1:0][BND_W-1:0] bnd_arr_t;
    typedef logic [CH_N-1:0][PAIR_N-1:0][7:0]     attr_arr_t;
    typedef logic [CH_N*RK_N-1:0][LIM_W-1:0]      lim_arr_t;

    typedef enum logic [CODE_W-1:0] {
        PG_EMPTY = 3'b000,
        PG_4K    = 3'b010,
        PG_8K    = 3'b011,
        PG_16K   = 3'b100
    } page_code_e;

    typedef struct packed {
        logic [RK_W-1:0]   rank;
        logic              chan;
        logic [CODE_W-1:0] page;
        logic              il;
        logic              oor;
        logic              cfg_err;
    } rsp_t;

    function automatic logic code_is_reserved(input logic [CODE_W-1:0] c);
        return !(c == PG_EMPTY || c == PG_4K || c == PG_8K || c == PG_16K);
    endfunction

    function automatic logic [CODE_W-1:0] field_of(input logic [7:0] b, input logic odd);
        return odd ? b[6:4] : b[2:0];
    endfunction
endpackage

// File: rtl/rbd_mode_detect.sv
module rbd_mode_detect
    import rbd_pkg::*;
(
    input  bnd_arr_t  bnd,
    input  attr_arr_t attr,
    output logic      interleaved
);
    logic [RK_N-1:0]   bnd_eq;
    logic [PAIR_N-1:0] attr_eq;

    for (genvar r = 0; r < RK_N; r++) begin : g_bnd
        assign bnd_eq[r] = (bnd[0][r] == bnd[1][r]);
    end

    for (genvar p = 0; p < PAIR_N; p++) begin : g_attr
        assign attr_eq[p] = (field_of(attr[0][p], 1'b0) == field_of(attr[1][p], 1'b0)) &&
                            (field_of(attr[0][p], 1'b1) == field_of(attr[1][p], 1'b1));
    end

    assign interleaved = (&bnd_eq) && (&attr_eq);
endmodule

// File: rtl/rbd_limit_gen.sv
module rbd_limit_gen
    import rbd_pkg::*;
(
    input  bnd_arr_t         bnd,
    input  logic             interleaved,
    output lim_arr_t         lim,
    output logic [LIM_W-1:0] top
);
    logic [LIM_W-1:0] ch0_top;
    assign ch0_top = LIM_W'(bnd[0][RK_N-1]);

    for (genvar c = 0; c < CH_N; c++) begin : g_ch
        for (genvar r = 0; r < RK_N; r++) begin : g_rk
            if (c == 0) begin : g_first
                assign lim[r] = interleaved ? {bnd[0][r], 1'b0} : LIM_W'(bnd[0][r]);
            end else begin : g_stack
                // zero limit never matches, so stacked entries drop out when interleaved
                assign lim[c*RK_N + r] = interleaved ? '0 : ch0_top + LIM_W'(bnd[c][r]);
            end
        end
    end

    assign top = interleaved ? lim[RK_N-1] : lim[CH_N*RK_N-1];
endmodule

// File: rtl/rbd_rank_search.sv
module rbd_rank_search
    import rbd_pkg::*;
(
    input  logic [LIM_W-1:0] unit,
    input  lim_arr_t         lim,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);
    logic [CH_N*RK_N-1:0] below;

    for (genvar k = 0; k < CH_N*RK_N; k++) begin : g_cmp
        assign below[k] = (unit < lim[k]);
    end

    always_comb begin
        idx = '0;
        for (int k = CH_N*RK_N-1; k >= 0; k--) begin
            if (below[k]) idx = IDX_W'(k);
        end
        hit = |below;
    end
endmodule

// File: rtl/rbd_decoder.sv
module rbd_decoder
    import rbd_pkg::*;
#(
    parameter int ADDR_W   = 33,
    parameter int UNIT_LSB = 25,
    parameter int IL_BIT   = 7
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [CH_N*RK_N*BND_W-1:0]   cfg_bound,
    input  logic [CH_N*PAIR_N*8-1:0]     cfg_attr,
    input  logic                         req_valid,
    input  logic [ADDR_W-1:0]            req_addr,
    output logic                         rsp_valid,
    output logic [RK_W-1:0]              rsp_rank,
    output logic                         rsp_chan,
    output logic [CODE_W-1:0]            rsp_page,
    output logic                         rsp_interleaved,
    output logic                         rsp_out_of_range,
    output logic                         rsp_cfg_err
);
    localparam int UNIT_W = ADDR_W - UNIT_LSB;

    bnd_arr_t         bnd;
    attr_arr_t        attr;
    logic             il;
    lim_arr_t         lim;
    logic [LIM_W-1:0] top;
    logic [LIM_W-1:0] unit;
    logic             hit;
    logic [IDX_W-1:0] idx;
    rsp_t             nxt, cur;

    assign bnd  = cfg_bound;
    assign attr = cfg_attr;
    assign unit = LIM_W'(req_addr[ADDR_W-1 -: UNIT_W]);

    rbd_mode_detect u_mode (.bnd(bnd), .attr(attr), .interleaved(il));
    rbd_limit_gen   u_lim  (.bnd(bnd), .interleaved(il), .lim(lim), .top(top));
    rbd_rank_search u_srch (.unit(unit), .lim(lim), .hit(hit), .idx(idx));

    logic              sel_chan;
    logic [RK_W-1:0]   sel_rank;
    logic [CODE_W-1:0] sel_code;

    always_comb begin
        sel_rank = idx[RK_W-1:0];
        sel_chan = il ? req_addr[IL_BIT] : idx[IDX_W-1];
        sel_code = field_of(attr[sel_chan][sel_rank[RK_W-1]], sel_rank[0]);

        nxt = '0;
        nxt.il = il;
        if (hit && unit < top) begin
            nxt.rank    = sel_rank;
            nxt.chan    = sel_chan;
            nxt.page    = sel_code;
            nxt.cfg_err = code_is_reserved(sel_code);
        end else begin
            nxt.oor = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            cur       <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) cur <= nxt;
        end
    end

    assign rsp_rank         = cur.rank;
    assign rsp_chan         = cur.chan;
    assign rsp_page         = cur.page;
    assign rsp_interleaved  = cur.il;
    assign rsp_out_of_range = cur.oor;
    assign rsp_cfg_err      = cur.cfg_err;
endmodule

// File: rtl/rbd_decoder_chk.sv
module rbd_decoder_chk #(
    parameter int ADDR_W = 33,
    parameter int IL_BIT = 7
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic              rsp_valid,
    input logic [1:0]        rsp_rank,
    input logic              rsp_chan,
    input logic [2:0]        rsp_page,
    input logic              rsp_interleaved,
    input logic              rsp_out_of_range,
    input logic              rsp_cfg_err
);
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid); // R1
    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid); // R1
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> ($stable(rsp_rank) && $stable(rsp_chan) && $stable(rsp_page)
                        && $stable(rsp_out_of_range) && $stable(rsp_cfg_err))); // R1
    AST_OOR_ZEROS: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_out_of_range) |->
        (rsp_rank == 2'd0 && !rsp_chan && rsp_page == 3'd0 && !rsp_cfg_err)); // R7
    AST_IL_CHAN: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_interleaved && !rsp_out_of_range) |->
        (rsp_chan == $past(req_addr[IL_BIT]))); // R5
    AST_ERR_RESERVED: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_cfg_err) |->
        (rsp_page == 3'd1 || rsp_page >= 3'd5)); // R9
    AST_LEGAL_NO_ERR: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_cfg_err) |-> (rsp_page == 3'd0 ||
        (rsp_page >= 3'd2 && rsp_page <= 3'd4))); // R9
endmodule

bind rbd_decoder rbd_decoder_chk #(.ADDR_W(ADDR_W), .IL_BIT(IL_BIT)) u_chk (.*);

// File: tb/rbd_decoder_bench.sv
module rbd_decoder_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] cfg_bound = '0;
    logic [31:0] cfg_attr = '0;
    logic        req_valid = 1'b0;
    logic [32:0] req_addr = '0;
    logic        rsp_valid;
    logic [1:0]  rsp_rank;
    logic        rsp_chan;
    logic [2:0]  rsp_page;
    logic        rsp_interleaved;
    logic        rsp_out_of_range;
    logic        rsp_cfg_err;

    always #2 clk = ~clk;

    rbd_decoder u_rbd_decoder (.*);

    int n_chk = 0;
    int n_fail = 0;
    int b [2][4];
    int at [4];
    int e_rank, e_chan, e_page, e_il, e_oor, e_err;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic apply_cfg();
        for (int c = 0; c < 2; c++) begin
            for (int r = 0; r < 4; r++) cfg_bound[8*(4*c+r) +: 8] = 8'(b[c][r]);
            for (int p = 0; p < 2; p++) cfg_attr[8*(2*c+p) +: 8] = 8'(at[2*c+p]);
        end
        @(negedge clk);
    endtask

    task automatic model(input logic [32:0] a);
        int unit, lo, hi, byt, code;
        bit found;
        e_il = 1;
        for (int r = 0; r < 4; r++) if (b[0][r] != b[1][r]) e_il = 0;
        for (int p = 0; p < 2; p++) if ((at[p] & 8'h77) != (at[p+2] & 8'h77)) e_il = 0;
        unit = int'(a >> 25);
        found = 0; e_rank = 0; e_chan = 0; lo = 0;
        for (int c = 0; c < (e_il ? 1 : 2); c++) begin
            for (int r = 0; r < 4; r++) begin
                hi = e_il ? 2*b[0][r] : (c == 1 ? b[0][3] : 0) + b[c][r];
                if (!found && unit >= lo && unit < hi) begin
                    found = 1; e_rank = r; e_chan = e_il ? int'(a[7]) : c;
                end
                lo = hi;
            end
        end
        e_oor = found ? 0 : 1;
        e_page = 0; e_err = 0;
        if (found) begin
            byt = at[2*e_chan + e_rank/2];
            code = (e_rank % 2) ? ((byt >> 4) & 7) : (byt & 7);
            e_page = code;
            e_err = (code == 1 || code >= 5) ? 1 : 0;
        end
    endtask

    task automatic sweep(input string tag);
        for (int u = 0; u < 256; u++) begin
            for (int s = 0; s < 2; s++) begin
                logic [32:0] a;
                a = {8'(u), 25'(u * 37 + s * 11)};
                a[7] = s[0];
                req_addr = a; req_valid = 1'b1;
                @(negedge clk);
                model(a);
                chk("R1", "valid", int'(rsp_valid), 1);
                chk(e_oor ? "R7" : tag, "rank", int'(rsp_rank), e_rank);
                chk(e_oor ? "R7" : tag, "chan", int'(rsp_chan), e_chan);
                chk("R7", "oor", int'(rsp_out_of_range), e_oor);
                chk("R8", "page", int'(rsp_page), e_page);
                chk("R9", "cfg_err", int'(rsp_cfg_err), e_err);
                chk("R10", "interleaved", int'(rsp_interleaved), e_il);
            end
        end
        req_valid = 1'b0;
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        chk("R1", "reset valid", int'(rsp_valid), 0);
        chk("R7", "reset oor", int'(rsp_out_of_range), 0);
        chk("R8", "reset page", int'(rsp_page), 0);
        rst = 1'b0;

        // R2 R3: stacked channels, empty rank 1 on ch0 and empty rank 2 on ch1
        b[0] = '{16, 16, 40, 64}; b[1] = '{0, 20, 20, 30};
        at = '{8'h02, 8'h43, 8'h20, 8'h30};
        apply_cfg(); sweep("R3");

        // R5: identical population, interleaved
        b[0] = '{10, 10, 50, 100}; b[1] = '{10, 10, 50, 100};
        at = '{8'h03, 8'h24, 8'h03, 8'h24};
        apply_cfg(); sweep("R5");

        // R4: reserved attribute bits differ, still interleaved
        at = '{8'h03, 8'h24, 8'h83, 8'h2C};
        apply_cfg(); sweep("R4");

        // R6: one boundary differs, stacked decode
        b[1] = '{10, 10, 50, 101};
        apply_cfg(); sweep("R6");

        // R9: reserved codes on populated ranks, total top 255
        b[0] = '{30, 60, 90, 120}; b[1] = '{30, 60, 90, 135};
        at = '{8'h51, 8'h76, 8'h32, 8'h42};
        apply_cfg(); sweep("R9");

        // R2: full-size rank 0 interleaved, never out of range
        b[0] = '{255, 255, 255, 255}; b[1] = '{255, 255, 255, 255};
        at = '{8'h04, 8'h00, 8'h04, 8'h00};
        apply_cfg(); sweep("R2");

        // R1: fields hold while no request is presented
        req_addr = {8'd0, 25'h80}; req_valid = 1'b1;
        @(negedge clk);
        chk("R1", "hold setup chan", int'(rsp_chan), 1);
        req_valid = 1'b0; req_addr = '0;
        @(negedge clk);
        chk("R1", "idle valid", int'(rsp_valid), 0);
        chk("R1", "idle chan held", int'(rsp_chan), 1);
        chk("R1", "idle page held", int'(rsp_page), 4);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule